// File: doc/BRIEF.md
# Clock PLL Operating Mode Controller

This block is the digital supervisor that decides which operating mode one clock-synthesis phase-locked loop is in. The loop comes out of reset into free-run, where the output follows the local reference alone. It then moves to lock acquisition as soon as the selected input clock is qualified. It enters locked mode when the external lock detector reports phase lock.

When the selected input is lost, the controller checks whether valid history of the input frequency exists. If it does, the loop goes to holdover. If it does not, the loop falls back to free-run. From holdover, a qualified input starts acquisition again.

The controller also produces three outputs for the loop:
- a loop-bandwidth select, which chooses the fast-lock bandwidth during acquisition when fast lock is enabled and the normal bandwidth at all other times;
- a loss-of-lock status bit;
- an enable that lets the holdover history accumulate only while the loop is locked.

Each loop in a device gets its own instance, and the instances run independently of each other. The analog loop, the oscillator and the lock detector are outside this block.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous), `mode` is 0 (reset), `lol` is 1, `bw_fast` is 0 and `hist_capture` is 0.
- R2: Mode encoding is 0 reset, 1 free-run, 2 acquire, 3 locked, 4 holdover. On the first rising clock edge after `rst_n` goes high, the mode changes from reset to free-run.
- R3: In free-run, while the selected input is not valid, the mode stays in free-run. The selected input is not valid when `clk_valid[in_sel]` is 0, and this holds whatever the other `clk_valid` bits are.
- R4: From free-run or holdover, on the edge where `clk_valid[in_sel]` is 1, the mode moves to acquire.
- R5: In acquire, when the selected input is valid and `phase_locked` is 1 on an edge, the mode moves to locked. Otherwise it stays in acquire.
- R6: When the selected input becomes invalid in locked or acquire and `hist_valid` is 1 on that edge, the mode moves to holdover.
- R7: When the selected input becomes invalid in locked or acquire and `hist_valid` is 0 on that edge, the mode moves to free-run.
- R8: In acquire, a selected-input failure and a `phase_locked` report on the same edge are resolved in favour of the failure. R6 and R7 then decide where the mode goes.
- R9: `bw_fast` is 1 exactly when the mode is acquire and `fastlock_en` is 1. With `fastlock_en` low, acquire uses the normal bandwidth (`bw_fast` 0).
- R10: `lol` is 1 in every mode except locked, where it is 0.
- R11: `hist_capture` is 1 only in locked mode.
- R12: In free-run and holdover, `phase_locked` has no effect. Holdover persists while the selected input stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_valid | input | NUM_INPUTS | Per-input clock qualification flags |
| in_sel | input | SEL_W | Index of the input the loop follows |
| phase_locked | input | 1 | Phase lock achieved, from the lock detector |
| hist_valid | input | 1 | Holdover history is usable |
| fastlock_en | input | 1 | Use fast-lock bandwidth during acquisition |
| mode | output | 3 | Current operating mode (encoding in R2) |
| bw_fast | output | 1 | 1 selects fast-lock bandwidth, 0 normal |
| lol | output | 1 | Loss-of-lock status |
| hist_capture | output | 1 | Holdover history accumulation enable |

## Verification
Two events can land on the same clock edge in acquisition: the selected input dropping and the lock detector reporting phase lock. The bench provokes this by clearing the selected `clk_valid` bit while raising `phase_locked` in one cycle. It runs this once with `hist_valid` low and once with it high. The scoreboard expects free-run or holdover respectively, never locked. A second coincidence is a change of `fastlock_en` during acquisition; that change must move `bw_fast` without moving the mode.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;

  typedef enum logic [2:0] {
    MODE_RESET    = 3'd0,
    MODE_FREERUN  = 3'd1,
    MODE_ACQUIRE  = 3'd2,
    MODE_LOCKED   = 3'd3,
    MODE_HOLDOVER = 3'd4
  } pll_mode_e;

  // Where a lost input sends the loop.
  function automatic pll_mode_e loss_target(input logic hist_ok);
    return hist_ok ? MODE_HOLDOVER : MODE_FREERUN;
  endfunction

  // Single-step transition rule; input failure outranks a lock report.
  function automatic pll_mode_e next_mode(input pll_mode_e cur,
                                          input logic      sel_ok,
                                          input logic      lock_ind,
                                          input logic      hist_ok);
    pll_mode_e nxt;
    nxt = cur;
    case (cur)
      MODE_RESET:    nxt = MODE_FREERUN;
      MODE_FREERUN:  if (sel_ok) nxt = MODE_ACQUIRE;
      MODE_HOLDOVER: if (sel_ok) nxt = MODE_ACQUIRE;
      MODE_ACQUIRE: begin
        if (!sel_ok)       nxt = loss_target(hist_ok);
        else if (lock_ind) nxt = MODE_LOCKED;
      end
      MODE_LOCKED:   if (!sel_ok) nxt = loss_target(hist_ok);
      default:       nxt = MODE_RESET;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pll_input_qual.sv
module pll_input_qual #(
  parameter int NUM_INPUTS = 4,
  parameter int SEL_W      = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
  input  logic [NUM_INPUTS-1:0] clk_valid,
  input  logic [SEL_W-1:0]      in_sel,
  output logic                  sel_ok
);
  localparam int PAD_W = 1 << SEL_W;

  logic [PAD_W-1:0] valid_pad;

  // Unpopulated select codes read as an invalid input.
  for (genvar i = 0; i < PAD_W; i++) begin : g_pad
    if (i < NUM_INPUTS) begin : g_real
      assign valid_pad[i] = clk_valid[i];
    end else begin : g_none
      assign valid_pad[i] = 1'b0;
    end
  end

  assign sel_ok = valid_pad[in_sel];
endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_ok,
  input  logic      phase_locked,
  input  logic      hist_valid,
  output pll_mode_e mode_q
);
  pll_mode_e mode_d;

  always_comb begin
    mode_d = next_mode(mode_q, sel_ok, phase_locked, hist_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RESET;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/pll_mode_decode.sv
module pll_mode_decode
  import pll_mode_pkg::*;
(
  input  pll_mode_e mode_q,
  input  logic      fastlock_en,
  output logic      bw_fast,
  output logic      lol,
  output logic      hist_capture
);
  logic is_locked;
  logic is_acquire;

  assign is_locked    = (mode_q == MODE_LOCKED);
  assign is_acquire   = (mode_q == MODE_ACQUIRE);
  assign bw_fast      = is_acquire & fastlock_en;
  assign lol          = ~is_locked;
  assign hist_capture = is_locked;
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
#(
  parameter int NUM_INPUTS = 4,
  parameter int SEL_W      = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INPUTS-1:0] clk_valid,
  input  logic [SEL_W-1:0]      in_sel,
  input  logic                  phase_locked,
  input  logic                  hist_valid,
  input  logic                  fastlock_en,
  output logic [2:0]            mode,
  output logic                  bw_fast,
  output logic                  lol,
  output logic                  hist_capture
);
  logic      sel_ok;
  pll_mode_e mode_q;

  pll_input_qual #(.NUM_INPUTS(NUM_INPUTS), .SEL_W(SEL_W)) qual_i (
    .clk_valid (clk_valid),
    .in_sel    (in_sel),
    .sel_ok    (sel_ok)
  );

  pll_mode_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_ok       (sel_ok),
    .phase_locked (phase_locked),
    .hist_valid   (hist_valid),
    .mode_q       (mode_q)
  );

  pll_mode_decode dec_i (
    .mode_q       (mode_q),
    .fastlock_en  (fastlock_en),
    .bw_fast      (bw_fast),
    .lol          (lol),
    .hist_capture (hist_capture)
  );

  assign mode = mode_q;
endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk
  import pll_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sel_ok,
  input logic       phase_locked,
  input logic       hist_valid,
  input logic       fastlock_en,
  input logic [2:0] mode,
  input logic       bw_fast,
  input logic       lol,
  input logic       hist_capture
);
  assert_reset_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RESET) |=> (mode == MODE_FREERUN));

  assert_stay_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FREERUN && !sel_ok) |=> (mode == MODE_FREERUN));

  assert_start_acq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_FREERUN || mode == MODE_HOLDOVER) && sel_ok) |=> (mode == MODE_ACQUIRE));

  assert_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACQUIRE && sel_ok && phase_locked) |=> (mode == MODE_LOCKED));

  assert_to_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_ACQUIRE || mode == MODE_LOCKED) && !sel_ok && hist_valid)
      |=> (mode == MODE_HOLDOVER));

  assert_to_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_ACQUIRE || mode == MODE_LOCKED) && !sel_ok && !hist_valid)
      |=> (mode == MODE_FREERUN));

  assert_fail_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_ACQUIRE && !sel_ok && phase_locked) |=> (mode != MODE_LOCKED));

  assert_bw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bw_fast |-> (mode == MODE_ACQUIRE && fastlock_en));

  assert_lol_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lol != hist_capture);

  assert_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hist_capture |-> (mode == MODE_LOCKED));

  assert_hold_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLDOVER && !sel_ok) |=> (mode == MODE_HOLDOVER));
endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_ok       (sel_ok),
  .phase_locked (phase_locked),
  .hist_valid   (hist_valid),
  .fastlock_en  (fastlock_en),
  .mode         (mode),
  .bw_fast      (bw_fast),
  .lol          (lol),
  .hist_capture (hist_capture)
);

// File: tb/pll_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pll_mode_ctrl_tb_top;
  localparam int NI = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] clk_valid = '0;
  logic [1:0]    in_sel = '0;
  logic          phase_locked = 1'b0;
  logic          hist_valid = 1'b0;
  logic          fastlock_en = 1'b0;
  logic [2:0]    mode;
  logic          bw_fast, lol, hist_capture;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] m;
    logic       bw;
    logic       ll;
    logic       cap;
    string      req;
  } exp_t;

  exp_t       sb_q[$];
  logic [2:0] model = 3'd0;

  always #2 clk = ~clk;

  pll_mode_ctrl #(.NUM_INPUTS(NI)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_valid(clk_valid), .in_sel(in_sel),
    .phase_locked(phase_locked), .hist_valid(hist_valid), .fastlock_en(fastlock_en),
    .mode(mode), .bw_fast(bw_fast), .lol(lol), .hist_capture(hist_capture)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Bench-side statement of the mode rules, written as a lookup by condition.
  function automatic logic [2:0] model_next(logic [2:0] cur, logic ok, logic pl, logic hv);
    logic lost;
    lost = (cur == 3'd2 || cur == 3'd3) && !ok;
    if (cur == 3'd0) return 3'd1;
    if (lost)        return hv ? 3'd4 : 3'd1;
    if ((cur == 3'd1 || cur == 3'd4) && ok) return 3'd2;
    if (cur == 3'd2 && pl) return 3'd3;
    return cur;
  endfunction

  // Called at a falling edge: drive, predict the next edge, push, wait one cycle.
  task automatic step(logic [NI-1:0] v, logic [1:0] s, logic pl, logic hv, logic fe, string req);
    exp_t e;
    clk_valid = v; in_sel = s; phase_locked = pl; hist_valid = hv; fastlock_en = fe;
    model = model_next(model, v[s], pl, hv);
    e.m = model; e.bw = (model == 3'd2) && fe; e.ll = (model != 3'd3);
    e.cap = (model == 3'd3); e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic check_reset(string req);
    checks++;
    if (mode !== 3'd0 || lol !== 1'b1 || bw_fast !== 1'b0 || hist_capture !== 1'b0) begin
      errors++;
      $display("FAIL %s: got mode=%0d lol=%b bw=%b cap=%b expected mode=0 lol=1 bw=0 cap=0",
               req, mode, lol, bw_fast, hist_capture);
    end
  endtask

  // Monitor: compare one queued item shortly after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (mode !== e.m || bw_fast !== e.bw || lol !== e.ll || hist_capture !== e.cap) begin
        errors++;
        $display("FAIL %s: got mode=%0d bw=%b lol=%b cap=%b expected mode=%0d bw=%b lol=%b cap=%b",
                 e.req, mode, bw_fast, lol, hist_capture, e.m, e.bw, e.ll, e.cap);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R1");
    rst_n = 1'b1;
    model = 3'd0;
    step(4'b0000, 2'd0, 1'b0, 1'b0, 1'b0, "R2");
    step(4'b1110, 2'd0, 1'b0, 1'b0, 1'b0, "R3");
    step(4'b0000, 2'd0, 1'b1, 1'b1, 1'b0, "R12 free-run ignores lock");
    step(4'b0001, 2'd0, 1'b0, 1'b0, 1'b1, "R4 R9");
    step(4'b0001, 2'd0, 1'b0, 1'b0, 1'b1, "R5 hold acquire");
    step(4'b0001, 2'd0, 1'b1, 1'b0, 1'b1, "R5 R10 R11");
    step(4'b0001, 2'd0, 1'b0, 1'b1, 1'b1, "R10 stay locked");
    step(4'b1110, 2'd0, 1'b0, 1'b1, 1'b1, "R6");
    step(4'b1110, 2'd0, 1'b1, 1'b1, 1'b1, "R12 holdover");
    step(4'b0100, 2'd2, 1'b0, 1'b0, 1'b0, "R4 R9 normal bw");
    step(4'b0000, 2'd2, 1'b1, 1'b0, 1'b1, "R8 R7");
    step(4'b1000, 2'd3, 1'b0, 1'b0, 1'b1, "R4");
    step(4'b1000, 2'd3, 1'b0, 1'b0, 1'b0, "R9 toggle");
    step(4'b1000, 2'd3, 1'b0, 1'b0, 1'b1, "R9 toggle back");
    step(4'b1000, 2'd3, 1'b1, 1'b0, 1'b1, "R5");
    step(4'b0111, 2'd3, 1'b0, 1'b0, 1'b0, "R7");
    step(4'b0010, 2'd1, 1'b0, 1'b0, 1'b1, "R4");
    step(4'b0000, 2'd1, 1'b1, 1'b1, 1'b1, "R8 R6");
    step(4'b0010, 2'd1, 1'b0, 1'b1, 1'b0, "R4 from holdover");
    step(4'b0010, 2'd1, 1'b1, 1'b1, 1'b0, "R5");
    rst_n = 1'b0;
    #1;
    check_reset("R1 async");
    @(negedge clk);
    check_reset("R1 held");
    rst_n = 1'b1;
    model = 3'd0;
    step(4'b0010, 2'd1, 1'b0, 1'b0, 1'b0, "R2 after reset");
    step(4'b0010, 2'd1, 1'b0, 1'b0, 1'b0, "R4");
    repeat (2) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule